// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block turns single requests from an internal storage controller into the strobe sequences of an 8-bit asynchronous NAND flash bus. A request names one of six operations and a target device: a command byte, an address byte, a data byte to write, a data byte to read, a full page read, or a wait for the device to leave its busy state. The sequencer drives the command latch, address latch, write strobe, read strobe, one of eight active-low chip enables, and the data bus with its output enable. It returns read bytes through a one-cycle response strobe.

Strobe low and high widths come from a speed-grade input that is latched whenever a request is accepted, so slow and fast devices can share one bus and the controller can switch grade between operations. The page size for page reads is a configuration input choosing between 512 and 2048 bytes. Ready/busy lines are brought in through a two-flop synchronizer. A wait operation first lets a programmable delay run out after the most recent write strobe rise, so a device has time to pull its line low, and then stalls until the line reads ready.

Top module: `nand_bus_seq`

## Requirements
- R1: A command request (op code 0) drives the byte on the data bus with output enable high and command latch high from the cycle after acceptance; one setup cycle with the write strobe high is followed by W cycles of write strobe low and W cycles high, and the command latch stays high through the rising edge, falling only in the first idle cycle.
- R2: An address request (op code 1) follows the R1 timing with the address latch high instead; the command and address latches are never high together.
- R3: A data write request (op code 2) follows the R1 timing with both latches low, and the driven byte does not change while the write strobe is low nor at its rising edge.
- R4: A single read request (op code 3) holds output enable low from the setup cycle, gives W cycles of read strobe low then W high, and returns the byte present on the data input in the last low cycle on rsp_data with rsp_valid and rsp_last high for exactly the first high cycle.
- R5: A page read request (op code 4) produces back-to-back read strobes, 512 of them when page_large is 0 and 2048 when it is 1, one response per byte, with rsp_last high only for the final byte.
- R6: After reset all chip enables are high; from the cycle after an accepted request exactly the enable whose index equals req_chip is low, and it stays so until the next accepted request.
- R7: W is 2 cycles for grade_sel 0, 3 for grade 1 and 5 for grades 2 and 3; the grade is captured at acceptance and changing it during an operation does not alter that operation's widths.
- R8: A wait request (op code 5) holds req_ready low until, first, at least D cycles have passed since the cycle the write strobe last rose (D is busy_dly, with values below 2 taken as 2) and, second, the synchronized ready/busy line with index req_chip modulo 2 reads high; a busy level on the other line has no effect.
- R9: Output enable is low in the cycle before every falling edge of the read strobe and for the whole low phase.
- R10: While reset is high, req_ready is 1, both strobes are high, both latches, output enable, the driven byte and rsp_valid are 0.
- R11: req_ready is high only while the sequencer is idle, and no strobe is low while it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 3 | Operation code (0 cmd, 1 addr, 2 write, 3 read, 4 page read, 5 wait) |
| req_chip | input | 3 | Target device index |
| req_data | input | 8 | Command, address or write byte |
| grade_sel | input | 2 | Device speed grade |
| page_large | input | 1 | Page size select (0: 512, 1: 2048 bytes) |
| busy_dly | input | 4 | Cycles after the last write strobe rise before ready/busy is trusted |
| rsp_valid | output | 1 | Read byte valid |
| rsp_data | output | 8 | Read byte |
| rsp_last | output | 1 | Final byte of a read operation |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_ce_n | output | 8 | Chip enables, active low |
| nf_dq_out | output | 8 | Driven data bus value |
| nf_dq_oe | output | 1 | Data bus output enable |
| nf_dq_in | input | 8 | Data bus value from the devices |
| nf_rb_n | input | 2 | Ready/busy lines, low while busy |

## Verification
The hardest case is a wait whose end is decided by the interplay of the post-write delay window and the moment the ready/busy line returns high through the synchronizer. The stimulus issues a wait straight after a write, with the busy release placed both before and after the delay expires, with a long programmed delay and with the clamped minimum, and once with the busy level placed on the line of another device so that only the delay governs the release. Each of these gives a different cycle for req_ready to return, which the bench predicts from the cycle of the last write strobe rise.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [2:0] {
        OP_CMD     = 3'd0,
        OP_ADDR    = 3'd1,
        OP_WBYTE   = 3'd2,
        OP_RBYTE   = 3'd3,
        OP_RPAGE   = 3'd4,
        OP_WAITRDY = 3'd5
    } nbs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_DELAY,
        ST_BUSY
    } nbs_state_e;

    typedef struct packed {
        logic valid;
        logic wr;
        logic rd;
        logic page;
        logic wt;
        logic cle;
        logic ale;
    } nbs_dec_t;

    function automatic nbs_dec_t nbs_decode(input logic [2:0] code);
        nbs_dec_t d;
        d = '0;
        case (code)
            OP_CMD:     begin d.valid = 1'b1; d.wr = 1'b1; d.cle = 1'b1; end
            OP_ADDR:    begin d.valid = 1'b1; d.wr = 1'b1; d.ale = 1'b1; end
            OP_WBYTE:   begin d.valid = 1'b1; d.wr = 1'b1; end
            OP_RBYTE:   begin d.valid = 1'b1; d.rd = 1'b1; end
            OP_RPAGE:   begin d.valid = 1'b1; d.rd = 1'b1; d.page = 1'b1; end
            OP_WAITRDY: begin d.valid = 1'b1; d.wt = 1'b1; end
            default:    d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/nbs_rb_sync.sv
module nbs_rb_sync #(
    parameter int NUM_RB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_RB-1:0] rb_n_async,
    output logic [NUM_RB-1:0] rb_ready
);
    generate
        for (genvar i = 0; i < NUM_RB; i++) begin : g_line
            logic stage1, stage2;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage1 <= 1'b1;
                    stage2 <= 1'b1;
                end else begin
                    stage1 <= rb_n_async[i];
                    stage2 <= stage1;
                end
            end
            assign rb_ready[i] = stage2;
        end
    endgenerate
endmodule

// File: rtl/nbs_gap_counter.sv
module nbs_gap_counter #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] SAT = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= SAT;
        end else if (clr) begin
            count <= '0;
        end else if (count != SAT) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/nbs_ce_decode.sv
module nbs_ce_decode #(
    parameter int NUM_CE = 8,
    parameter int CHIP_W = 3
) (
    input  logic              en,
    input  logic [CHIP_W-1:0] sel,
    output logic [NUM_CE-1:0] ce_n
);
    generate
        for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
            assign ce_n[i] = ~(en && (sel == CHIP_W'(i)));
        end
    endgenerate
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nbs_pkg::*;
#(
    parameter int NUM_CE        = 8,
    parameter int NUM_RB        = 2,
    parameter int DQ_W          = 8,
    parameter int WIDTH_FAST    = 2,
    parameter int WIDTH_MID     = 3,
    parameter int WIDTH_SLOW    = 5,
    parameter int PAGE_SMALL    = 512,
    parameter int PAGE_LARGE    = 2048,
    parameter int DLY_W         = 4,
    parameter int MIN_BUSY_DLY  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [2:0]                req_op,
    input  logic [$clog2(NUM_CE)-1:0] req_chip,
    input  logic [DQ_W-1:0]           req_data,
    input  logic [1:0]                grade_sel,
    input  logic                      page_large,
    input  logic [DLY_W-1:0]          busy_dly,
    output logic                      rsp_valid,
    output logic [DQ_W-1:0]           rsp_data,
    output logic                      rsp_last,
    output logic                      nf_cle,
    output logic                      nf_ale,
    output logic                      nf_we_n,
    output logic                      nf_re_n,
    output logic [NUM_CE-1:0]         nf_ce_n,
    output logic [DQ_W-1:0]           nf_dq_out,
    output logic                      nf_dq_oe,
    input  logic [DQ_W-1:0]           nf_dq_in,
    input  logic [NUM_RB-1:0]         nf_rb_n
);
    localparam int CHIP_W   = $clog2(NUM_CE);
    localparam int TW       = $clog2(WIDTH_SLOW + 1);
    localparam int BC_W     = $clog2(PAGE_LARGE);
    localparam int SINCE_W  = DLY_W + 1;
    localparam int RB_IDX_W = (NUM_RB > 1) ? $clog2(NUM_RB) : 1;

    nbs_state_e           st;
    nbs_dec_t             dec_q;
    logic [TW-1:0]        tcnt;
    logic [TW-1:0]        width_q;
    logic [TW-1:0]        width_sel;
    logic [BC_W-1:0]      bytes_left;
    logic [DLY_W-1:0]     dly_q;
    logic [DLY_W-1:0]     dly_eff;
    logic [CHIP_W-1:0]    chip_q;
    logic                 ce_en;
    logic [SINCE_W-1:0]   since_we;
    logic [NUM_RB-1:0]    rb_ready;
    logic [RB_IDX_W-1:0]  rb_idx;
    logic                 phase_end;
    logic                 we_rise;
    nbs_dec_t             dec_in;

    always_comb begin
        case (grade_sel)
            2'd0:    width_sel = TW'(WIDTH_FAST);
            2'd1:    width_sel = TW'(WIDTH_MID);
            default: width_sel = TW'(WIDTH_SLOW);
        endcase
    end

    assign dec_in    = nbs_decode(req_op);
    assign dly_eff   = (busy_dly < DLY_W'(MIN_BUSY_DLY)) ? DLY_W'(MIN_BUSY_DLY) : busy_dly;
    assign req_ready = (st == ST_IDLE);
    assign phase_end = (tcnt == width_q - 1'b1);
    assign we_rise   = (st == ST_LOW) && phase_end && dec_q.wr;
    assign rb_idx    = chip_q[RB_IDX_W-1:0];

    nbs_rb_sync #(.NUM_RB(NUM_RB)) u_rb_sync (
        .clk        (clk),
        .rst        (rst),
        .rb_n_async (nf_rb_n),
        .rb_ready   (rb_ready)
    );

    nbs_gap_counter #(.CW(SINCE_W)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .clr   (we_rise),
        .count (since_we)
    );

    nbs_ce_decode #(.NUM_CE(NUM_CE), .CHIP_W(CHIP_W)) u_ce (
        .en   (ce_en),
        .sel  (chip_q),
        .ce_n (nf_ce_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            dec_q      <= '0;
            tcnt       <= '0;
            width_q    <= TW'(WIDTH_FAST);
            bytes_left <= '0;
            dly_q      <= DLY_W'(MIN_BUSY_DLY);
            chip_q     <= '0;
            ce_en      <= 1'b0;
            nf_cle     <= 1'b0;
            nf_ale     <= 1'b0;
            nf_we_n    <= 1'b1;
            nf_re_n    <= 1'b1;
            nf_dq_out  <= '0;
            nf_dq_oe   <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            rsp_last   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid && dec_in.valid) begin
                        dec_q   <= dec_in;
                        width_q <= width_sel;
                        dly_q   <= dly_eff;
                        chip_q  <= req_chip;
                        ce_en   <= 1'b1;
                        nf_cle  <= dec_in.cle;
                        nf_ale  <= dec_in.ale;
                        if (dec_in.wr) begin
                            nf_dq_oe  <= 1'b1;
                            nf_dq_out <= req_data;
                        end else if (dec_in.rd) begin
                            nf_dq_oe  <= 1'b0;
                        end
                        if (dec_in.page) begin
                            bytes_left <= page_large ? BC_W'(PAGE_LARGE - 1)
                                                     : BC_W'(PAGE_SMALL - 1);
                        end else begin
                            bytes_left <= '0;
                        end
                        st <= dec_in.wt ? ST_DELAY : ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    st   <= ST_LOW;
                    tcnt <= '0;
                    if (dec_q.wr) nf_we_n <= 1'b0;
                    else          nf_re_n <= 1'b0;
                end
                ST_LOW: begin
                    if (phase_end) begin
                        st      <= ST_HIGH;
                        tcnt    <= '0;
                        nf_we_n <= 1'b1;
                        nf_re_n <= 1'b1;
                        if (dec_q.rd) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= nf_dq_in;
                            rsp_last  <= (bytes_left == '0);
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        tcnt <= '0;
                        if (bytes_left != '0) begin
                            bytes_left <= bytes_left - 1'b1;
                            st         <= ST_LOW;
                            nf_re_n    <= 1'b0;
                        end else begin
                            st     <= ST_IDLE;
                            nf_cle <= 1'b0;
                            nf_ale <= 1'b0;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_DELAY: begin
                    if (since_we >= {1'b0, dly_q}) st <= ST_BUSY;
                end
                ST_BUSY: begin
                    if (rb_ready[rb_idx]) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
    parameter int NUM_CE = 8,
    parameter int DQ_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              nf_cle,
    input logic              nf_ale,
    input logic              nf_we_n,
    input logic              nf_re_n,
    input logic [NUM_CE-1:0] nf_ce_n,
    input logic [DQ_W-1:0]   nf_dq_out,
    input logic              nf_dq_oe
);
    p_cmd_hold_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(nf_we_n) |-> (nf_cle == $past(nf_cle)) && (nf_ale == $past(nf_ale)));

    p_latch_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(nf_cle && nf_ale));

    p_wdata_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!nf_we_n || $rose(nf_we_n)) |-> ($stable(nf_dq_out) && nf_dq_oe));

    p_rsp_at_re_rise_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $rose(nf_re_n));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(!nf_we_n && !nf_re_n));

    p_ce_single_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~nf_ce_n));

    p_turnaround_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(nf_re_n) |-> (!$past(nf_dq_oe) && !nf_dq_oe));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (nf_we_n && nf_re_n));
endmodule

bind nand_bus_seq nbs_checker #(.NUM_CE(NUM_CE), .DQ_W(DQ_W)) u_nbs_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .nf_cle    (nf_cle),
    .nf_ale    (nf_ale),
    .nf_we_n   (nf_we_n),
    .nf_re_n   (nf_re_n),
    .nf_ce_n   (nf_ce_n),
    .nf_dq_out (nf_dq_out),
    .nf_dq_oe  (nf_dq_oe)
);

// File: tb/tb_nand_bus_seq.sv
module tb_nand_bus_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CE     = 8;
    localparam int NUM_RB     = 2;
    localparam int DQ_W       = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = '0;
    logic [2:0]        req_chip = '0;
    logic [DQ_W-1:0]   req_data = '0;
    logic [1:0]        grade_sel = '0;
    logic              page_large = 1'b0;
    logic [3:0]        busy_dly = '0;
    logic              rsp_valid;
    logic [DQ_W-1:0]   rsp_data;
    logic              rsp_last;
    logic              nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [NUM_CE-1:0] nf_ce_n;
    logic [DQ_W-1:0]   nf_dq_out;
    logic [DQ_W-1:0]   nf_dq_in = '0;
    logic [NUM_RB-1:0] nf_rb_n = '1;

    nand_bus_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_chip(req_chip), .req_data(req_data),
        .grade_sel(grade_sel), .page_large(page_large), .busy_dly(busy_dly),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_ce_n(nf_ce_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
        .nf_dq_in(nf_dq_in), .nf_rb_n(nf_rb_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int last_h = -1000;

    logic              e_ready, e_cle, e_ale, e_we, e_re, e_oe, e_rv, e_last;
    logic [NUM_CE-1:0] e_ce_n;
    logic [DQ_W-1:0]   e_dout, e_rdata;

    function automatic int grade_w(input logic [1:0] g);
        case (g)
            2'd0:    return 2;
            2'd1:    return 3;
            default: return 5;
        endcase
    endfunction

    function automatic logic [7:0] pat(input int k, input int seed);
        return 8'((k * 29 + seed * 7 + 3) & 255);
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all(input string tag);
        cmp(tag, "req_ready", 32'(req_ready), 32'(e_ready));
        cmp(tag, "cle", 32'(nf_cle), 32'(e_cle));
        cmp(tag, "ale", 32'(nf_ale), 32'(e_ale));
        cmp(tag, "we_n", 32'(nf_we_n), 32'(e_we));
        cmp(tag, "re_n", 32'(nf_re_n), 32'(e_re));
        cmp(tag, "ce_n", 32'(nf_ce_n), 32'(e_ce_n));
        cmp(tag, "dq_oe", 32'(nf_dq_oe), 32'(e_oe));
        cmp(tag, "dq_out", 32'(nf_dq_out), 32'(e_dout));
        cmp(tag, "rsp_valid", 32'(rsp_valid), 32'(e_rv));
        if (e_rv) begin
            cmp(tag, "rsp_data", 32'(rsp_data), 32'(e_rdata));
            cmp(tag, "rsp_last", 32'(rsp_last), 32'(e_last));
        end
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        compare_all(tag);
    endtask

    // One request with strobe cycles; ops 0..2 write, 3..4 read
    task automatic run_op(input logic [2:0] op, input int chip, input logic [7:0] data,
                          input int nbytes, input int seed, input string tag, input bit bump);
        int  w  = grade_w(grade_sel);
        bit  wr = (op <= 3'd2);
        req_valid = 1'b1;
        req_op    = op;
        req_chip  = 3'(chip);
        req_data  = data;
        e_ready = 1'b0;
        e_ce_n  = ~(NUM_CE'(1) << chip);
        e_cle   = (op == 3'd0);
        e_ale   = (op == 3'd1);
        e_we    = 1'b1;
        e_re    = 1'b1;
        e_rv    = 1'b0;
        if (wr) begin
            e_oe   = 1'b1;
            e_dout = data;
        end else begin
            e_oe = 1'b0;
        end
        step(tag);
        req_valid = 1'b0;
        if (bump) grade_sel = grade_sel + 2'd1;
        for (int k = 0; k < nbytes; k++) begin
            if (!wr) nf_dq_in = pat(k, seed);
            for (int i = 0; i < w; i++) begin
                if (wr) e_we = 1'b0;
                else    e_re = 1'b0;
                e_rv = 1'b0;
                step(tag);
            end
            for (int i = 0; i < w; i++) begin
                e_we    = 1'b1;
                e_re    = 1'b1;
                e_rv    = (!wr && i == 0);
                e_rdata = pat(k, seed);
                e_last  = (k == nbytes - 1);
                step(tag);
                if (wr && i == 0) last_h = cyc;
            end
        end
        e_rv    = 1'b0;
        e_cle   = 1'b0;
        e_ale   = 1'b0;
        e_ready = 1'b1;
        step(tag);
    endtask

    // Wait request; hold = cycles the chosen line stays low, other = busy on the other line
    task automatic run_wait(input int chip, input int dly_in, input int hold,
                            input bit other, input string tag);
        int a    = cyc;
        int d    = (dly_in < 2) ? 2 : dly_in;
        int td   = (last_h + d > a + 1) ? last_h + d : a + 1;
        int w    = td + 1;
        int line = other ? 1 - (chip % 2) : chip % 2;
        int rise = a + 1 + hold;
        int u    = w;
        if (!other && hold > 0 && rise + 2 > u) u = rise + 2;
        busy_dly  = 4'(dly_in);
        req_valid = 1'b1;
        req_op    = 3'd5;
        req_chip  = 3'(chip);
        if (hold > 0) nf_rb_n[line] = 1'b0;
        e_ce_n = ~(NUM_CE'(1) << chip);
        for (int c = a + 1; c <= u + 1; c++) begin
            e_ready = (c == u + 1);
            step(tag);
            if (c == a + 1) req_valid = 1'b0;
            if (hold > 0 && c == rise) nf_rb_n[line] = 1'b1;
        end
        nf_rb_n = '1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        e_ready = 1'b1; e_cle = 1'b0; e_ale = 1'b0; e_we = 1'b1; e_re = 1'b1;
        e_oe = 1'b0; e_rv = 1'b0; e_last = 1'b0; e_ce_n = '1; e_dout = '0; e_rdata = '0;
        repeat (3) @(negedge clk);
        compare_all("R10");
        rst = 1'b0;
        step("R10");

        // grade 0 (W=2): the four single-byte kinds on chip 3
        run_op(3'd0, 3, 8'h70, 1, 0, "R1", 1'b0);
        run_op(3'd1, 3, 8'h12, 1, 0, "R2", 1'b0);
        run_op(3'd2, 3, 8'hA5, 1, 0, "R3", 1'b0);
        run_op(3'd3, 3, 8'h00, 1, 5, "R4", 1'b0);
        run_op(3'd3, 5, 8'h00, 1, 6, "R9", 1'b0);

        // grade changes: W=3 kept although grade moves during the op, then W=5
        grade_sel = 2'd1;
        run_op(3'd0, 0, 8'hFF, 1, 0, "R7", 1'b1);
        run_op(3'd2, 7, 8'h3C, 1, 0, "R7", 1'b0);
        grade_sel = 2'd3;
        run_op(3'd3, 7, 8'h00, 1, 2, "R7", 1'b0);
        run_op(3'd1, 6, 8'hC3, 1, 0, "R2", 1'b0);

        // every chip enable in turn
        grade_sel = 2'd0;
        for (int c = 0; c < NUM_CE; c++) run_op(3'd1, c, 8'(c), 1, 0, "R6", 1'b0);

        // ready/busy waits
        run_op(3'd2, 2, 8'h5A, 1, 0, "R8", 1'b0);
        run_wait(2, 0, 6, 1'b0, "R8");
        run_op(3'd2, 2, 8'h5B, 1, 0, "R8", 1'b0);
        run_wait(2, 9, 3, 1'b0, "R8");
        run_op(3'd2, 3, 8'h5C, 1, 0, "R8", 1'b0);
        run_wait(3, 4, 12, 1'b0, "R8");
        run_wait(1, 4, 10, 1'b1, "R8");
        run_wait(1, 0, 5, 1'b0, "R8");

        // page reads in both geometries
        page_large = 1'b0;
        run_op(3'd4, 4, 8'h00, 512, 9, "R5", 1'b0);
        page_large = 1'b1;
        run_op(3'd4, 6, 8'h00, 2048, 11, "R5", 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule